// File: doc/BRIEF.md
# Hex Record Parser with Checksum

This block sits between a UART receiver and a UART transmitter and turns a stream of ASCII characters into complete hex-encoded records. A record opens with a colon and carries, as pairs of hex characters, a byte count, a 16-bit address, a record type, up to the configured number of payload bytes and a checksum byte, followed by a line terminator. Characters are converted and stored as they arrive, and a running 8-bit sum is kept over every byte of the record.

Nothing is issued while a record is still arriving. Once the terminator is seen, a record whose byte sum is zero is presented on a command bundle (type, address, count, payload) and held there until the consumer pulses done; the block then answers with a full stop. A record whose sum is non-zero, or whose count exceeds the buffer, is discarded and answered with an upper-case X. Any type value is handed through; what a type means is left to the consumer.

Top module: `hexrec_parser`

## Requirements
- R1: After reset cmd_valid_o and tx_valid_o are 0 and rx_ready_o is 1.
- R2: Characters received while waiting for a colon (0x3A) produce no status byte and no command.
- R3: A well-formed record with a good checksum raises cmd_valid_o one cycle after its terminator is accepted, with cmd_addr_o taken from the first address pair as the high byte, cmd_count_o equal to the count, and payload byte i (0 = first received) on cmd_data_o[8i+7:8i]; the bundle stays stable while cmd_valid_o is high.
- R4: The checksum is good when the 8-bit sum of count, both address bytes, type, all payload bytes and the checksum byte is zero; otherwise the block emits 0x58 ('X') for one cycle and issues no command.
- R5: A count above MAX_BYTES makes the block emit 0x58 one cycle after the second count character and discard the record; a count equal to MAX_BYTES is accepted.
- R6: Hex characters 0-9, A-F and a-f are all accepted.
- R7: Any non-hex character inside a record, or a character other than CR/LF where the terminator is due, aborts the record silently and the block waits for a new colon.
- R8: Either CR (0x0D) or LF (0x0A) terminates a record.
- R9: While a command is pending rx_ready_o is 0 and input bytes have no effect.
- R10: A cycle with cmd_done_i high while cmd_valid_o is high drops cmd_valid_o on the next cycle and emits 0x2E ('.') for exactly one cycle.
- R11: The record type is passed to cmd_type_o unchanged, including 0x00, 0x01 and other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received ASCII character |
| rx_valid_i | input | 1 | rx_data_i holds a character |
| rx_ready_o | output | 1 | Block can take a character |
| tx_data_o | output | 8 | Status character to transmit |
| tx_valid_o | output | 1 | tx_data_o is valid this cycle |
| cmd_valid_o | output | 1 | Command bundle valid, pending done |
| cmd_type_o | output | 8 | Record type |
| cmd_addr_o | output | 16 | Record address |
| cmd_count_o | output | $clog2(MAX_BYTES+1) | Number of payload bytes |
| cmd_data_o | output | 8*MAX_BYTES | Payload, byte i at bits 8i+7:8i |
| cmd_done_i | input | 1 | Consumer finished the command |

## Verification
The bench builds the block with the default MAX_BYTES of 32, which keeps the buffer small enough to fill completely in one directed record. That puts both edges of the count limit within reach: a 32-byte record that must be issued intact and a count of 33 that must be rejected right after its count field.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BYTES,
    PH_EOL,
    PH_CMD
  } phase_e;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_ERR   = 8'h58;
  localparam logic [7:0] CH_OK    = 8'h2E;
endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble (
  input  logic [7:0] char_i,
  output logic       vld_o,
  output logic [3:0] val_o
);
  logic [7:0] off;

  always_comb begin
    vld_o = 1'b0;
    off   = 8'h00;
    if (char_i >= 8'h30 && char_i <= 8'h39) begin
      vld_o = 1'b1;
      off   = char_i - 8'h30;
    end else if (char_i >= 8'h41 && char_i <= 8'h46) begin
      vld_o = 1'b1;
      off   = char_i - 8'h37;
    end else if (char_i >= 8'h61 && char_i <= 8'h66) begin
      vld_o = 1'b1;
      off   = char_i - 8'h57;
    end
    val_o = off[3:0];
  end
endmodule

// File: rtl/hexrec_byte_asm.sv
module hexrec_byte_asm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       nib_vld_i,
  input  logic [3:0] nib_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  logic       half_q;
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      hi_q   <= 4'h0;
    end else if (clr_i) begin
      half_q <= 1'b0;
    end else if (nib_vld_i) begin
      half_q <= ~half_q;
      if (!half_q) hi_q <= nib_i;
    end
  end

  assign byte_vld_o = nib_vld_i && half_q;
  assign byte_o     = {hi_q, nib_i};
endmodule

// File: rtl/hexrec_buf.sv
module hexrec_buf #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         data_i,
  output logic [DEPTH*8-1:0] flat_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             slot_q <= 8'h00;
      else if (we_i && idx_i == IDX_W'(g))     slot_q <= data_i;
    end
    assign flat_o[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int POS_W = $clog2(MAX_BYTES + 6),
  localparam int BUF_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             rx_data_i,
  input  logic                   rx_valid_i,
  output logic                   rx_ready_o,
  output logic [7:0]             tx_data_o,
  output logic                   tx_valid_o,
  output logic                   cmd_valid_o,
  output logic [7:0]             cmd_type_o,
  output logic [15:0]            cmd_addr_o,
  output logic [CNT_W-1:0]       cmd_count_o,
  output logic [MAX_BYTES*8-1:0] cmd_data_o,
  input  logic                   cmd_done_i
);
  phase_e           phase_q;
  logic [POS_W-1:0] pos_q;
  logic [7:0]       sum_q;
  logic [CNT_W-1:0] count_q;
  logic [15:0]      addr_q;
  logic [7:0]       type_q;

  logic       accept, hex_vld, byte_vld, is_eol;
  logic [3:0] hex_val;
  logic [7:0] byte_val;
  logic       in_data, is_csum;
  logic [POS_W-1:0] data_pos;

  assign rx_ready_o = (phase_q != PH_CMD);
  assign accept     = rx_valid_i && rx_ready_o;
  assign is_eol     = (rx_data_i == CH_CR) || (rx_data_i == CH_LF);

  hexrec_nibble i_nibble (
    .char_i (rx_data_i),
    .vld_o  (hex_vld),
    .val_o  (hex_val)
  );

  hexrec_byte_asm i_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept && phase_q == PH_IDLE),
    .nib_vld_i  (accept && phase_q == PH_BYTES && hex_vld),
    .nib_i      (hex_val),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_val)
  );

  // payload occupies positions 4 .. 4+count-1, checksum at 4+count
  assign data_pos = pos_q - POS_W'(4);
  assign is_csum  = (pos_q >= POS_W'(4)) && (data_pos == POS_W'(count_q));
  assign in_data  = (pos_q >= POS_W'(4)) && !is_csum;

  hexrec_buf #(
    .DEPTH (MAX_BYTES),
    .IDX_W (BUF_W)
  ) i_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (byte_vld && in_data),
    .idx_i  (data_pos[BUF_W-1:0]),
    .data_i (byte_val),
    .flat_o (cmd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      pos_q      <= '0;
      sum_q      <= 8'h00;
      count_q    <= '0;
      addr_q     <= 16'h0000;
      type_q     <= 8'h00;
      tx_valid_o <= 1'b0;
      tx_data_o  <= 8'h00;
    end else begin
      tx_valid_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept && rx_data_i == CH_COLON) begin
            phase_q <= PH_BYTES;
            pos_q   <= '0;
            sum_q   <= 8'h00;
          end
        end
        PH_BYTES: begin
          if (accept && !hex_vld) begin
            phase_q <= PH_IDLE;
          end else if (byte_vld) begin
            sum_q <= sum_q + byte_val;
            pos_q <= pos_q + POS_W'(1);
            if (pos_q == POS_W'(0)) begin
              if (byte_val > 8'(MAX_BYTES)) begin
                tx_valid_o <= 1'b1;
                tx_data_o  <= CH_ERR;
                phase_q    <= PH_IDLE;
              end else begin
                count_q <= byte_val[CNT_W-1:0];
              end
            end
            if (pos_q == POS_W'(1)) addr_q[15:8] <= byte_val;
            if (pos_q == POS_W'(2)) addr_q[7:0]  <= byte_val;
            if (pos_q == POS_W'(3)) type_q       <= byte_val;
            if (is_csum) phase_q <= PH_EOL;
          end
        end
        PH_EOL: begin
          if (accept) begin
            if (is_eol && sum_q == 8'h00) begin
              phase_q <= PH_CMD;
            end else begin
              if (is_eol) begin
                tx_valid_o <= 1'b1;
                tx_data_o  <= CH_ERR;
              end
              phase_q <= PH_IDLE;
            end
          end
        end
        PH_CMD: begin
          if (cmd_done_i) begin
            tx_valid_o <= 1'b1;
            tx_data_o  <= CH_OK;
            phase_q    <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (phase_q == PH_CMD);
  assign cmd_type_o  = type_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_count_o = count_q;
endmodule

// File: rtl/hexrec_checker.sv
module hexrec_checker #(
  parameter int MAX_BYTES = 32,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       rx_data_i,
  input logic             rx_valid_i,
  input logic             rx_ready_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             cmd_valid_o,
  input logic [7:0]       cmd_type_o,
  input logic [15:0]      cmd_addr_o,
  input logic [CNT_W-1:0] cmd_count_o,
  input logic             cmd_done_i
);
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_type_o)
      && $stable(cmd_addr_o) && $stable(cmd_count_o)); // R3

  AST_DONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i |=> !cmd_valid_o && tx_valid_o && tx_data_o == 8'h2E); // R10

  AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o); // R10

  AST_TX_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o == 8'h58 || tx_data_o == 8'h2E)); // R4

  AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_count_o <= CNT_W'(MAX_BYTES)); // R5

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !rx_ready_o); // R9

  AST_CMD_AFTER_EOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(rx_valid_i)
      && ($past(rx_data_i) == 8'h0D || $past(rx_data_i) == 8'h0A)); // R8
endmodule

bind hexrec_parser hexrec_checker #(.MAX_BYTES(MAX_BYTES)) i_hexrec_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_data_i   (rx_data_i),
  .rx_valid_i  (rx_valid_i),
  .rx_ready_o  (rx_ready_o),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_type_o  (cmd_type_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_count_o (cmd_count_o),
  .cmd_done_i  (cmd_done_i)
);

// File: tb/test_hexrec_parser.sv
module test_hexrec_parser;
  localparam int MAX_BYTES = 32;
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] tx_data;
  logic tx_valid;
  logic cmd_valid;
  logic [7:0] cmd_type;
  logic [15:0] cmd_addr;
  logic [CNT_W-1:0] cmd_count;
  logic [MAX_BYTES*8-1:0] cmd_data;
  logic cmd_done = 1'b0;

  always #10 clk = ~clk;

  hexrec_parser #(.MAX_BYTES(MAX_BYTES)) i_hexrec_parser (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .cmd_valid_o(cmd_valid), .cmd_type_o(cmd_type), .cmd_addr_o(cmd_addr),
    .cmd_count_o(cmd_count), .cmd_data_o(cmd_data), .cmd_done_i(cmd_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int tx_cnt = 0;
  logic [7:0] tx_last = 8'h00;

  always @(posedge clk) if (tx_valid) begin
    tx_cnt++;
    tx_last = tx_data;
  end

  typedef struct packed {
    logic [8*24-1:0] s;
    logic            cmd;
    logic [7:0]      typ;
    logic [15:0]     addr;
    logic [5:0]      cnt;
    logic [7:0]      d0;
    logic [7:0]      dl;
    logic [7:0]      tx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{":0300300002337A1E\r\n", 1'b1, 8'h00, 16'h0030, 6'd3, 8'h02, 8'h7A, 8'h2E}, // R3 R11
    '{":00000001FF\n",         1'b1, 8'h01, 16'h0000, 6'd0, 8'h00, 8'h00, 8'h2E}, // R8 R11
    '{":02abcd10beefc9\r",     1'b1, 8'h10, 16'hABCD, 6'd2, 8'hBE, 8'hEF, 8'h2E}, // R6
    '{":0300300002337A1F\r",   1'b0, 8'h00, 16'h0000, 6'd0, 8'h00, 8'h00, 8'h58}, // R4
    '{":2100000000\r\n",       1'b0, 8'h00, 16'h0000, 6'd0, 8'h00, 8'h00, 8'h58}, // R5
    '{"ab\r:00000001FF\r",     1'b1, 8'h01, 16'h0000, 6'd0, 8'h00, 8'h00, 8'h2E}, // R2
    '{":0G00000001FF\r",       1'b0, 8'h00, 16'h0000, 6'd0, 8'h00, 8'h00, 8'h00}  // R7
  };

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
  endfunction

  task automatic send_hex(input logic [7:0] b);
    send(hexc(b[7:4]));
    send(hexc(b[3:0]));
  endtask

  task automatic finish_cmd(input string req);
    chk(!rx_ready, req, 256'(rx_ready), 256'd0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    chk(!cmd_valid, "R10 cmd_valid drop", 256'(cmd_valid), 256'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [MAX_BYTES*8-1:0] exp_data;
    logic [7:0] csum;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", 256'(cmd_valid), 256'd0);
    chk(tx_valid == 1'b0, "R1 tx_valid", 256'(tx_valid), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1 rx_ready", 256'(rx_ready), 256'd1);

    for (int v = 0; v < NV; v++) begin
      tx_cnt = 0;
      for (int i = 23; i >= 0; i--) begin
        if (VECS[v].s[i*8 +: 8] != 8'h00) send(VECS[v].s[i*8 +: 8]);
      end
      chk(cmd_valid == VECS[v].cmd, $sformatf("R3 vec%0d cmd_valid", v), 256'(cmd_valid), 256'(VECS[v].cmd));
      if (VECS[v].cmd) begin
        chk(cmd_type == VECS[v].typ, $sformatf("R11 vec%0d type", v), 256'(cmd_type), 256'(VECS[v].typ));
        chk(cmd_addr == VECS[v].addr, $sformatf("R3 vec%0d addr", v), 256'(cmd_addr), 256'(VECS[v].addr));
        chk(cmd_count == VECS[v].cnt, $sformatf("R3 vec%0d count", v), 256'(cmd_count), 256'(VECS[v].cnt));
        if (VECS[v].cnt != 0) begin
          chk(cmd_data[7:0] == VECS[v].d0, $sformatf("R3 vec%0d first byte", v), 256'(cmd_data[7:0]), 256'(VECS[v].d0));
          chk(cmd_data[VECS[v].cnt*8-1 -: 8] == VECS[v].dl, $sformatf("R3 vec%0d last byte", v),
              256'(cmd_data[VECS[v].cnt*8-1 -: 8]), 256'(VECS[v].dl));
        end
        finish_cmd("R9 ready low");
      end else begin
        repeat (2) @(negedge clk);
      end
      if (VECS[v].tx == 8'h00) begin
        chk(tx_cnt == 0, $sformatf("R7 vec%0d no status", v), 256'(tx_cnt), 256'd0);
      end else begin
        chk(tx_cnt == 1 && tx_last == VECS[v].tx, $sformatf("R4 R10 vec%0d status", v),
            256'(tx_last), 256'(VECS[v].tx));
      end
    end

    // R5 boundary: full buffer record
    tx_cnt = 0;
    csum = 8'(MAX_BYTES) + 8'h12;
    send(8'h3A);
    send_hex(8'(MAX_BYTES));
    send_hex(8'h12);
    send_hex(8'h00);
    send_hex(8'h00);
    for (int i = 0; i < MAX_BYTES; i++) begin
      exp_data[i*8 +: 8] = 8'(i * 7 + 1);
      csum = csum + 8'(i * 7 + 1);
      send_hex(8'(i * 7 + 1));
    end
    send_hex(8'h00 - csum);
    send(8'h0A);
    chk(cmd_valid == 1'b1, "R5 full record accepted", 256'(cmd_valid), 256'd1);
    chk(cmd_count == CNT_W'(MAX_BYTES), "R5 full count", 256'(cmd_count), 256'(MAX_BYTES));
    chk(cmd_data == exp_data, "R3 full payload", 256'(cmd_data), 256'(exp_data));
    chk(cmd_addr == 16'h1200, "R3 full addr", 256'(cmd_addr), 256'h1200);

    // R9: input while pending has no effect
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = (i == 0) ? 8'h3A : 8'h31;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(cmd_valid && cmd_addr == 16'h1200 && cmd_type == 8'h00, "R9 pending bundle held",
        256'({cmd_valid, cmd_addr}), 256'({1'b1, 16'h1200}));
    chk(tx_cnt == 0, "R9 no status while pending", 256'(tx_cnt), 256'd0);
    finish_cmd("R9 ready low full");
    chk(tx_cnt == 1 && tx_last == 8'h2E, "R10 full ack", 256'(tx_last), 256'h2E);
    // the held-off colon must not have opened a record
    send(8'h30); send(8'h30); send(8'h30); send(8'h30);
    send(8'h30); send(8'h30); send(8'h30); send(8'h31);
    send(8'h46); send(8'h46); send(8'h0D);
    repeat (2) @(negedge clk);
    chk(!cmd_valid && tx_cnt == 1, "R9 held-off bytes ignored", 256'({cmd_valid, 8'(tx_cnt)}), 256'h01);

    // R7: wrong terminator aborts silently
    tx_cnt = 0;
    send(8'h3A);
    send_hex(8'h00); send_hex(8'h00); send_hex(8'h00); send_hex(8'h01); send_hex(8'hFF);
    send(8'h20);
    send(8'h0D);
    repeat (2) @(negedge clk);
    chk(!cmd_valid && tx_cnt == 0, "R7 bad terminator", 256'({cmd_valid, 8'(tx_cnt)}), 256'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule